// File: doc/BRIEF.md
# Bridge Control Register File

This block is the control-port register file of a two-direction FIFO bridge. A host on the control port selects a resource with a 2-bit address, an active-low chip select, a read/write level and an access strobe. The resources are the two FIFO data paths, a 9-bit bypass, a bank of eight 16-bit configuration registers and a shared status/command location. The FIFO arrays and the bypass transceiver live outside this block, which only decodes access strobes for them.

A write to the command location carries an opcode in bits 11:8 and an operand in bits 2:0. The block turns each command into one-cycle pulses for the pointer logic. These cover pointer resets, saving and restoring the read and write pointers, and single pointer increments. Commands also select the configuration register that the configuration address reaches, set the DMA transfer direction, and can restore the configuration bank to its defaults. Reads of the status location return a fixed map of the eight internal FIFO flags and the DMA direction. One configuration register routes any internal flag to each of four flag outputs. Two others drive six general-purpose pins and set each pin's direction.

Top module: `bridge_ctl_regs`

## Requirements
- R1: With `cs_n` low and `stb` high, address 00 gives `ab_push` on a write and `ba_pop` on a read, and address 01 gives `byp_wr` or `byp_rd`. With `cs_n` high no strobe fires. At most one strobe is high at a time.
- R2: After `rst_n` is released, configuration registers 0 to 3 and 5 to 7 read 0000h, register 4 reads 6420h, the register selector is 0, `dma_dir` is 0 and all command pulses are low.
- R3: A command write uses opcode = `wdata[11:8]`. Opcodes 2, 3, 4, 5, 8 and 9 raise, in order, `ld_reread`, `ld_rewrite`, `restore_rd`, `restore_wr`, `inc_rd` and `inc_wr` for exactly the one cycle after the write edge.
- R4: Opcode 0 is a reset. Operand bit 0 pulses `rst_ba_ptr`, bit 1 pulses `rst_ab_ptr` and bit 2 pulses `rst_dma_req`, all in the cycle after the write. Operand 000 pulses nothing.
- R5: Opcode 0 with operand 111 (reset all) also returns all eight configuration registers to their R2 defaults.
- R6: Opcode 1 stores operand bits 2:0 as the register selector. Later reads and writes at address 10 reach configuration register number selector.
- R7: Opcode 6 sets `dma_dir` to operand bit 0, where 0 means B-to-A write and 1 means A-to-B read. Status bit 3 shows `dma_dir`.
- R8: A read at address 11 returns a status word. It has bit 3 = direction and bits 4..7 = `flag_in[0]`, `flag_in[1]`, `flag_in[6]`, `flag_in[7]`. Bits 12..15 are `flag_in[2]`, `flag_in[3]`, `flag_in[4]`, `flag_in[5]`, and all other bits are 0. Flag index order is A-to-B empty, almost-empty, full, almost-full, then B-to-A empty, almost-empty, full, almost-full.
- R9: `flag_pin[p]` shows the flag selected by bits 4p+3:4p of configuration register 4. Codes 0 to 7 select `flag_in[code]`, and codes 8 to 15 drive the pin low.
- R10: `pio_oe` equals register 7 bits 5:0 and `pio_out` equals register 6 bits 5:0. Reading register 6 returns the stored bit where the pin is an output and `pio_in` where it is an input, with bits 15:6 as stored.
- R11: Opcodes 7 and 10 to 15, and any write while `cs_n` is high, change no register and raise no pulse.
- R12: Command word bits 15:12 and 7:3 have no effect on decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| stb | input | 1 | Access strobe, one per cycle of access |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 2 | Resource address |
| wdata | input | 16 | Write data / command word |
| rdata | output | 16 | Read data for configuration and status |
| ab_push | output | 1 | Write strobe to the A-to-B FIFO |
| ba_pop | output | 1 | Read strobe to the B-to-A FIFO |
| byp_wr | output | 1 | Bypass write strobe |
| byp_rd | output | 1 | Bypass read strobe |
| flag_in | input | 8 | Internal FIFO flags |
| flag_pin | output | 4 | Routed external flags |
| dma_dir | output | 1 | DMA direction, 0 = B-to-A write |
| rst_ba_ptr | output | 1 | Pulse: reset B-to-A pointers |
| rst_ab_ptr | output | 1 | Pulse: reset A-to-B pointers |
| rst_dma_req | output | 1 | Pulse: reset DMA request logic |
| ld_reread | output | 1 | Pulse: save read pointer as reread mark |
| ld_rewrite | output | 1 | Pulse: save write pointer as rewrite mark |
| restore_rd | output | 1 | Pulse: load read pointer from reread mark |
| restore_wr | output | 1 | Pulse: load write pointer from rewrite mark |
| inc_rd | output | 1 | Pulse: advance port-B read pointer |
| inc_wr | output | 1 | Pulse: advance port-B write pointer |
| pio_in | input | 6 | General-purpose pin levels |
| pio_out | output | 6 | General-purpose output values |
| pio_oe | output | 6 | General-purpose output enables |

## Verification
The assertions check on every cycle that the bus strobes are mutually exclusive and absent when deselected. They also check that the save, restore and increment pulses never overlap, that each increment pulse traces back to its own command write, and that the direction and pin enables change only after a register or command write. Only the bench's sweeps can show the values themselves. These are the full status bit map over all flag patterns, every flag-select code on every pin, the readback mix for all 64 direction masks, and the restore of defaults by reset all.

// File: rtl/bcr_pkg.sv
package bcr_pkg;

    localparam int OPC_W = 4;
    localparam int OPD_W = 3;

    typedef enum logic [OPC_W-1:0] {
        OP_RESET       = 4'h0,
        OP_SEL_CFG     = 4'h1,
        OP_SAVE_RD     = 4'h2,
        OP_SAVE_WR     = 4'h3,
        OP_RESTORE_RD  = 4'h4,
        OP_RESTORE_WR  = 4'h5,
        OP_DIR         = 4'h6,
        OP_INC_RD      = 4'h8,
        OP_INC_WR      = 4'h9
    } opcode_e;

    typedef struct packed {
        logic rst_ba;
        logic rst_ab;
        logic rst_dma;
        logic save_rd;
        logic save_wr;
        logic restore_rd;
        logic restore_wr;
        logic inc_rd;
        logic inc_wr;
    } pulse_t;

    typedef enum logic [1:0] {
        AD_FIFO   = 2'b00,
        AD_BYPASS = 2'b01,
        AD_CFG    = 2'b10,
        AD_CMD    = 2'b11
    } addr_e;

endpackage

// File: rtl/bcr_cmd_decode.sv
module bcr_cmd_decode
    import bcr_pkg::*;
(
    input  logic             valid,
    input  logic [OPC_W-1:0] opc,
    input  logic [OPD_W-1:0] opd,
    output pulse_t           pulse,
    output logic             sel_cfg,
    output logic             set_dir,
    output logic             rst_cfg
);
    always_comb begin
        pulse   = '0;
        sel_cfg = 1'b0;
        set_dir = 1'b0;
        rst_cfg = 1'b0;
        if (valid) begin
            case (opc)
                OP_RESET: begin
                    pulse.rst_ba  = opd[0];
                    pulse.rst_ab  = opd[1];
                    pulse.rst_dma = opd[2];
                    rst_cfg       = &opd;
                end
                OP_SEL_CFG:    sel_cfg          = 1'b1;
                OP_SAVE_RD:    pulse.save_rd    = 1'b1;
                OP_SAVE_WR:    pulse.save_wr    = 1'b1;
                OP_RESTORE_RD: pulse.restore_rd = 1'b1;
                OP_RESTORE_WR: pulse.restore_wr = 1'b1;
                OP_DIR:        set_dir          = 1'b1;
                OP_INC_RD:     pulse.inc_rd     = 1'b1;
                OP_INC_WR:     pulse.inc_wr     = 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/bcr_flag_router.sv
module bcr_flag_router #(
    parameter int NFLAG = 8,
    parameter int NPIN  = 4,
    parameter int SELW  = 4
) (
    input  logic [NPIN*SELW-1:0] sel_map,
    input  logic [NFLAG-1:0]     flags,
    output logic [NPIN-1:0]      pins
);
    localparam int IDXW = $clog2(NFLAG);

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        logic [SELW-1:0] code;
        assign code = sel_map[p*SELW +: SELW];
        assign pins[p] = (int'(code) < NFLAG) ? flags[code[IDXW-1:0]] : 1'b0;
    end
endmodule

// File: rtl/bcr_status_pack.sv
module bcr_status_pack #(
    parameter int DW = 16
) (
    input  logic [7:0]    flags,
    input  logic          dir,
    output logic [DW-1:0] status
);
    always_comb begin
        status     = '0;
        status[3]  = dir;
        status[4]  = flags[0];
        status[5]  = flags[1];
        status[6]  = flags[6];
        status[7]  = flags[7];
        status[12] = flags[2];
        status[13] = flags[3];
        status[14] = flags[4];
        status[15] = flags[5];
    end
endmodule

// File: rtl/bridge_ctl_regs.sv
module bridge_ctl_regs
    import bcr_pkg::*;
#(
    parameter int DW    = 16,
    parameter int NPIO  = 6,
    parameter int NPIN  = 4,
    parameter int FSELW = 4,
    parameter int NFLAG = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             stb,
    input  logic             wr,
    input  logic [1:0]       addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             ab_push,
    output logic             ba_pop,
    output logic             byp_wr,
    output logic             byp_rd,
    input  logic [NFLAG-1:0] flag_in,
    output logic [NPIN-1:0]  flag_pin,
    output logic             dma_dir,
    output logic             rst_ba_ptr,
    output logic             rst_ab_ptr,
    output logic             rst_dma_req,
    output logic             ld_reread,
    output logic             ld_rewrite,
    output logic             restore_rd,
    output logic             restore_wr,
    output logic             inc_rd,
    output logic             inc_wr,
    input  logic [NPIO-1:0]  pio_in,
    output logic [NPIO-1:0]  pio_out,
    output logic [NPIO-1:0]  pio_oe
);
    localparam int NCFG     = 1 << OPD_W;
    localparam int SELW     = OPD_W;
    localparam int FLAG_REG = 4;
    localparam int PIO_REG  = 6;
    localparam int DIR_REG  = 7;

    typedef logic [NCFG-1:0][DW-1:0] bank_t;

    function automatic bank_t cfg_defaults();
        bank_t b;
        b = '0;
        for (int p = 0; p < NPIN; p++) begin
            b[FLAG_REG][p*FSELW +: FSELW] = FSELW'(2 * p);
        end
        return b;
    endfunction

    localparam bank_t CFG_DEF = cfg_defaults();

    typedef struct packed {
        bank_t          cfg;
        logic [SELW-1:0] sel;
        logic           dir;
        pulse_t         pulse;
    } state_t;

    localparam state_t RESET_ST = '{cfg: CFG_DEF, sel: '0, dir: 1'b0, pulse: '0};

    state_t st_d, st_q;

    logic   acc;
    logic   cmd_wr;
    logic   cfg_wr;
    pulse_t dec_pulse;
    logic   dec_sel;
    logic   dec_dir;
    logic   dec_rst_cfg;
    logic [DW-1:0] status_w;
    logic [DW-1:0] cfg_word;

    assign acc    = stb && !cs_n;
    assign cmd_wr = acc && wr && (addr == AD_CMD);
    assign cfg_wr = acc && wr && (addr == AD_CFG);

    assign ab_push = acc &&  wr && (addr == AD_FIFO);
    assign ba_pop  = acc && !wr && (addr == AD_FIFO);
    assign byp_wr  = acc &&  wr && (addr == AD_BYPASS);
    assign byp_rd  = acc && !wr && (addr == AD_BYPASS);

    bcr_cmd_decode u_dec (
        .valid   (cmd_wr),
        .opc     (wdata[11:8]),
        .opd     (wdata[2:0]),
        .pulse   (dec_pulse),
        .sel_cfg (dec_sel),
        .set_dir (dec_dir),
        .rst_cfg (dec_rst_cfg)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pulse = dec_pulse;
        if (cfg_wr) begin
            st_d.cfg[st_q.sel] = wdata;
        end
        if (dec_sel) begin
            st_d.sel = wdata[SELW-1:0];
        end
        if (dec_dir) begin
            st_d.dir = wdata[0];
        end
        if (dec_rst_cfg) begin
            st_d.cfg = CFG_DEF;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= RESET_ST;
        end else begin
            st_q <= st_d;
        end
    end

    bcr_flag_router #(
        .NFLAG (NFLAG),
        .NPIN  (NPIN),
        .SELW  (FSELW)
    ) u_route (
        .sel_map (st_q.cfg[FLAG_REG][NPIN*FSELW-1:0]),
        .flags   (flag_in),
        .pins    (flag_pin)
    );

    bcr_status_pack #(
        .DW (DW)
    ) u_stat (
        .flags  (flag_in[7:0]),
        .dir    (st_q.dir),
        .status (status_w)
    );

    assign pio_oe  = st_q.cfg[DIR_REG][NPIO-1:0];
    assign pio_out = st_q.cfg[PIO_REG][NPIO-1:0];

    always_comb begin
        cfg_word = st_q.cfg[st_q.sel];
        if (int'(st_q.sel) == PIO_REG) begin
            cfg_word[NPIO-1:0] = (pio_out & pio_oe) | (pio_in & ~pio_oe);
        end
    end

    always_comb begin
        rdata = '0;
        if (!cs_n && !wr) begin
            case (addr)
                AD_CFG:  rdata = cfg_word;
                AD_CMD:  rdata = status_w;
                default: rdata = '0;
            endcase
        end
    end

    assign dma_dir     = st_q.dir;
    assign rst_ba_ptr  = st_q.pulse.rst_ba;
    assign rst_ab_ptr  = st_q.pulse.rst_ab;
    assign rst_dma_req = st_q.pulse.rst_dma;
    assign ld_reread   = st_q.pulse.save_rd;
    assign ld_rewrite  = st_q.pulse.save_wr;
    assign restore_rd  = st_q.pulse.restore_rd;
    assign restore_wr  = st_q.pulse.restore_wr;
    assign inc_rd      = st_q.pulse.inc_rd;
    assign inc_wr      = st_q.pulse.inc_wr;

endmodule

// File: rtl/bridge_ctl_regs_chk.sv
module bridge_ctl_regs_chk #(
    parameter int NPIO = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cs_n,
    input logic            stb,
    input logic            wr,
    input logic [1:0]      addr,
    input logic [3:0]      cmd_opc,
    input logic            ab_push,
    input logic            ba_pop,
    input logic            byp_wr,
    input logic            byp_rd,
    input logic            dma_dir,
    input logic            ld_reread,
    input logic            ld_rewrite,
    input logic            restore_rd,
    input logic            restore_wr,
    input logic            inc_rd,
    input logic            inc_wr,
    input logic [NPIO-1:0] pio_oe
);
    // R1: strobes exclusive and silent when deselected
    a_r1_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ab_push, ba_pop, byp_wr, byp_rd}));
    a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !(ab_push || ba_pop || byp_wr || byp_rd));

    // R3: one command pulse at a time
    a_r3_pulse_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld_reread, ld_rewrite, restore_rd, restore_wr, inc_rd, inc_wr}));
    a_r3_inc_rd_cause: assert property (@(posedge clk) disable iff (!rst_n)
        inc_rd |-> $past(stb && !cs_n && wr && addr == 2'b11 && cmd_opc == 4'h8));
    a_r3_inc_wr_cause: assert property (@(posedge clk) disable iff (!rst_n)
        inc_wr |-> $past(stb && !cs_n && wr && addr == 2'b11 && cmd_opc == 4'h9));

    // R11: deselected access raises no pulse
    a_r11_no_pulse_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) |-> !(ld_reread || ld_rewrite || restore_rd || restore_wr || inc_rd || inc_wr));

    // R7: direction changes only after a command write
    a_r7_dir_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dma_dir) |-> $past(stb && !cs_n && wr && addr == 2'b11 && cmd_opc == 4'h6));

    // R10: pin enables change only after a configuration or command write
    a_r10_oe_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pio_oe) |-> $past(stb && !cs_n && wr && addr[1]));
endmodule

bind bridge_ctl_regs bridge_ctl_regs_chk #(.NPIO(NPIO)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .stb        (stb),
    .wr         (wr),
    .addr       (addr),
    .cmd_opc    (wdata[11:8]),
    .ab_push    (ab_push),
    .ba_pop     (ba_pop),
    .byp_wr     (byp_wr),
    .byp_rd     (byp_rd),
    .dma_dir    (dma_dir),
    .ld_reread  (ld_reread),
    .ld_rewrite (ld_rewrite),
    .restore_rd (restore_rd),
    .restore_wr (restore_wr),
    .inc_rd     (inc_rd),
    .inc_wr     (inc_wr),
    .pio_oe     (pio_oe)
);

// File: tb/sim_bridge_ctl_regs.sv
`timescale 1ns/1ps
module sim_bridge_ctl_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        stb = 1'b0;
    logic        wr = 1'b0;
    logic [1:0]  addr = 2'b00;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        ab_push, ba_pop, byp_wr, byp_rd;
    logic [7:0]  flag_in = '0;
    logic [3:0]  flag_pin;
    logic        dma_dir;
    logic        rst_ba_ptr, rst_ab_ptr, rst_dma_req;
    logic        ld_reread, ld_rewrite, restore_rd, restore_wr, inc_rd, inc_wr;
    logic [5:0]  pio_in = '0;
    logic [5:0]  pio_out, pio_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] m_cfg [8];
    logic [2:0]  m_sel;
    logic        m_dir;

    always #5 clk = ~clk;

    bridge_ctl_regs u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .stb(stb), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ab_push(ab_push), .ba_pop(ba_pop),
        .byp_wr(byp_wr), .byp_rd(byp_rd), .flag_in(flag_in), .flag_pin(flag_pin),
        .dma_dir(dma_dir), .rst_ba_ptr(rst_ba_ptr), .rst_ab_ptr(rst_ab_ptr),
        .rst_dma_req(rst_dma_req), .ld_reread(ld_reread), .ld_rewrite(ld_rewrite),
        .restore_rd(restore_rd), .restore_wr(restore_wr), .inc_rd(inc_rd),
        .inc_wr(inc_wr), .pio_in(pio_in), .pio_out(pio_out), .pio_oe(pio_oe)
    );

    function automatic logic [8:0] pulses_now();
        return {rst_ba_ptr, rst_ab_ptr, rst_dma_req, ld_reread, ld_rewrite,
                restore_rd, restore_wr, inc_rd, inc_wr};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_defaults();
        for (int i = 0; i < 8; i++) m_cfg[i] = 16'h0000;
        m_cfg[4] = 16'h6420;
    endtask

    // one strobed access, returns at the negedge after the capturing edge
    task automatic access(input logic a_cs_n, input logic [1:0] a, input logic w,
                          input logic [15:0] d);
        @(negedge clk);
        cs_n = a_cs_n; stb = 1'b1; wr = w; addr = a; wdata = d;
        @(negedge clk);
        stb = 1'b0; cs_n = 1'b1; wr = 1'b0; wdata = '0;
    endtask

    task automatic cmd(input logic [3:0] op, input logic [2:0] opd, input logic junk);
        access(1'b0, 2'b11, 1'b1, junk ? {4'hA, op, 5'b10101, opd} : {4'h0, op, 5'b0, opd});
    endtask

    task automatic read_at(input logic [1:0] a, output logic [15:0] v);
        cs_n = 1'b0; stb = 1'b0; wr = 1'b0; addr = a;
        #1 v = rdata;
        cs_n = 1'b1;
    endtask

    task automatic cfg_write(input logic [2:0] idx, input logic [15:0] v);
        cmd(4'h1, idx, 1'b0); m_sel = idx;
        access(1'b0, 2'b10, 1'b1, v); m_cfg[idx] = v;
    endtask

    task automatic cfg_read(input logic [2:0] idx, output logic [15:0] v);
        cmd(4'h1, idx, 1'b0); m_sel = idx;
        read_at(2'b10, v);
    endtask

    function automatic logic [15:0] exp_status(input logic [7:0] f, input logic d);
        logic [15:0] s;
        s = '0;
        s[3] = d; s[4] = f[0]; s[5] = f[1]; s[6] = f[6]; s[7] = f[7];
        s[12] = f[2]; s[13] = f[3]; s[14] = f[4]; s[15] = f[5];
        return s;
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        model_defaults(); m_sel = 3'd0; m_dir = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset state
        chk("R2 pulses", 32'(pulses_now()), 32'h0);
        chk("R2 dir", 32'(dma_dir), 32'h0);
        read_at(2'b10, v); chk("R2 selector 0", 32'(v), 32'h0);
        for (int i = 0; i < 8; i++) begin
            cfg_read(3'(i), v);
            chk("R2 cfg default", 32'(v), 32'(m_cfg[i]));
        end

        // R1: address decode, all combinations
        for (int c = 0; c < 2; c++)
            for (int a = 0; a < 4; a++)
                for (int w = 0; w < 2; w++) begin
                    logic [3:0] e;
                    @(negedge clk);
                    cs_n = 1'(c); addr = 2'(a); wr = 1'(w); stb = 1'b1;
                    #1;
                    e = '0;
                    if (c == 0 && a == 0) e = w ? 4'b1000 : 4'b0100;
                    if (c == 0 && a == 1) e = w ? 4'b0010 : 4'b0001;
                    chk("R1 strobes", 32'({ab_push, ba_pop, byp_wr, byp_rd}), 32'(e));
                    if (!(c == 0 && a[1])) begin
                        stb = 1'b0;
                    end
                    stb = 1'b0; cs_n = 1'b1; wr = 1'b0;
                end

        // R3 R4 R5 R6 R7 R11 R12: sweep all opcodes and operands
        for (int op = 0; op < 16; op++)
            for (int od = 0; od < 8; od++) begin
                logic [8:0] ep;
                logic       junk;
                junk = (od % 2) == 1;
                // perturb a config register so reset-all is observable
                if (op == 0 && od == 7) cfg_write(3'd2, 16'hBEEF);
                cmd(4'(op), 3'(od), junk);
                ep = '0;
                case (op)
                    0: begin ep[8] = od[0]; ep[7] = od[1]; ep[6] = od[2];
                              if (od == 7) begin model_defaults(); end end
                    1: m_sel = 3'(od);
                    2: ep[5] = 1'b1;
                    3: ep[4] = 1'b1;
                    4: ep[3] = 1'b1;
                    5: ep[2] = 1'b1;
                    6: m_dir = od[0];
                    8: ep[1] = 1'b1;
                    9: ep[0] = 1'b1;
                    default: ;
                endcase
                if (op == 0) chk("R4 reset pulses", 32'(pulses_now()), 32'(ep));
                else if (op == 7 || op > 9) chk("R11 reserved silent", 32'(pulses_now()), 32'(ep));
                else chk("R3 R12 command pulse", 32'(pulses_now()), 32'(ep));
                @(negedge clk);
                chk("R3 pulse one cycle", 32'(pulses_now()), 32'h0);
                chk("R7 dir", 32'(dma_dir), 32'(m_dir));
                if (op == 1) begin
                    read_at(2'b10, v);
                    chk("R6 selected register", 32'(v), 32'(m_cfg[m_sel]));
                end
                if (op == 0 && od == 7) begin
                    cfg_read(3'd2, v); chk("R5 reset all cfg2", 32'(v), 32'h0);
                    cfg_read(3'd4, v); chk("R5 reset all cfg4", 32'(v), 32'h6420);
                end
            end

        // R8: status map over all flag patterns, both directions
        for (int d = 0; d < 2; d++) begin
            cmd(4'h6, 3'(d), 1'b0); m_dir = 1'(d);
            for (int f = 0; f < 256; f++) begin
                flag_in = 8'(f);
                read_at(2'b11, v);
                chk("R8 R7 status", 32'(v), 32'(exp_status(8'(f), 1'(d))));
            end
        end

        // R9: every code on every pin
        for (int c = 0; c < 16; c++) begin
            logic [15:0] map;
            for (int p = 0; p < 4; p++) map[p*4 +: 4] = 4'((c + 5 * p) % 16);
            cfg_write(3'd4, map);
            for (int f = 0; f < 10; f++) begin
                logic [7:0] fv;
                logic [3:0] ex;
                fv = (f < 8) ? 8'(1 << f) : ((f == 8) ? 8'hFF : 8'h5A);
                flag_in = fv;
                #1;
                for (int p = 0; p < 4; p++) begin
                    logic [3:0] cd;
                    cd = map[p*4 +: 4];
                    ex[p] = (cd < 8) ? fv[cd[2:0]] : 1'b0;
                end
                chk("R9 flag routing", 32'(flag_pin), 32'(ex));
            end
        end

        // R10: all direction masks
        for (int m = 0; m < 64; m++) begin
            logic [15:0] stored;
            stored = 16'hC3A5 ^ 16'(m * 16'h0101);
            cfg_write(3'd7, {10'h2AA, 6'(m)});
            cfg_write(3'd6, stored);
            pio_in = ~stored[5:0] ^ 6'(m);
            #1;
            chk("R10 oe", 32'(pio_oe), 32'(m));
            chk("R10 out", 32'(pio_out), 32'(stored[5:0]));
            read_at(2'b10, v);
            chk("R10 readback", 32'(v),
                32'({stored[15:6], (stored[5:0] & 6'(m)) | (pio_in & ~6'(m))}));
        end

        // R11: writes while deselected change nothing
        cfg_write(3'd3, 16'h1234);
        access(1'b1, 2'b10, 1'b1, 16'hFFFF);
        chk("R11 deselected cmd none", 32'(pulses_now()), 32'h0);
        access(1'b1, 2'b11, 1'b1, 16'h0800);
        chk("R11 deselected no pulse", 32'(pulses_now()), 32'h0);
        access(1'b1, 2'b11, 1'b1, 16'h0102);
        read_at(2'b10, v);
        chk("R11 deselected cfg kept", 32'(v), 32'h1234);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule